// File: doc/BRIEF.md
# Banked External Interrupt Controller

This block watches a set of external interrupt inputs from pads, grouped into banks of up to 32 lines. Each line has a 4-bit trigger mode, an enable bit and a sticky pending bit. The raw pad inputs are first passed through a synchroniser. Each line then raises its pending bit when the event its mode selects occurs: a rising edge, a falling edge, either edge, an active-high level or an active-low level. One registered interrupt request output tells the processor that some enabled line has an event pending.

Software reaches the block through a single-cycle 32-bit register port. The interrupt registers begin at byte address 0x200. Each bank takes a 0x20-byte window that holds its trigger-mode words, its enable word and its pending word. An interrupt handler reads the pending word of each bank. It then writes the same value back, which clears exactly the events it saw. To turn a line off, software clears its enable bit and then writes a one to its pending bit. Read data appears on the cycle after the read strobe.

Top module: `eint_ctrl`

## Requirements
- R1: Bank b occupies byte addresses 0x200+0x20*b up to 0x21F+0x20*b. Line n's trigger code sits in the word at bank offset 4*(n/8), in bits [4*(n%8)+3 : 4*(n%8)], and reads back as written. Read data is registered and valid the cycle after `bus_rd`.
- R2: The trigger codes are 0 for a rising edge, 1 for a falling edge, 2 for a high level, 3 for a low level and 4 for both edges. Edges are found by comparing the two-flop synchronised pad value with its previous sample.
- R3: The enable word at bank offset 0x10 holds one bit per line, with bit n for line n. It reads back as written.
- R4: Trigger codes 5 to 15 never set a pending bit.
- R5: A pending bit is set only while its enable bit is 1. In a level mode it is set again on every cycle that the level stays active, even right after a clear.
- R6: The pending word at bank offset 0x14 is write-one-to-clear. A 0 bit in the written data leaves that pending bit unchanged. Writing back a value just read clears exactly the bits in it.
- R7: If a detected event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Reset, which is synchronous and active high, clears every trigger code, enable bit and pending bit.
- R9: Reads of offsets that are not implemented return 0. This covers bank offsets 0x18 and 0x1C, addresses past the last bank and addresses below 0x200.
- R10: `irq_out` is a register holding the OR, over all banks, of (pending AND enable). It drops one cycle after the last such bit clears. A line whose enable is cleared and whose pending bit is then cleared contributes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pads | input | NUM_BANKS*LINES (160) | Raw asynchronous pad inputs; bit 32*b+n is line n of bank b |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The random trials pick a bank, a line, a trigger code (some reserved), a pad level at the moment of arming and a later pad level. Each trial then compares the whole pending word and `irq_out` with a model. That model separates edge from level behaviour, rising from falling, and the reserved codes from the valid ones. It also shows that a level still active at arming sets the bit again straight after the clear. Directed cases cover the following:
- a pad edge arriving in the same cycle as a software clear;
- a write-back that clears two observed lines while leaving a third line pending;
- the two-step disable sequence;
- the cycle on which `irq_out` drops;
- trigger-code readback at several line positions, followed by reads of unimplemented offsets made while the registers hold non-zero values.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [3:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  // Event detector: cur is the synchronised sample, prv the one before it.
  function automatic logic trig_hit(logic [3:0] code, logic cur, logic prv);
    logic r;
    case (code)
      TRIG_RISE: r = cur & ~prv;
      TRIG_FALL: r = ~cur & prv;
      TRIG_HIGH: r = cur;
      TRIG_LOW:  r = ~cur;
      TRIG_BOTH: r = cur ^ prv;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prv
);
  logic [WIDTH-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur = sync_q;
  assign prv = last_q;
endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int LINES = 32,
  parameter int OFF_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [OFF_W-1:0]   off,
  input  logic [31:0]        wdata,
  input  logic [LINES-1:0]   cur,
  input  logic [LINES-1:0]   prv,
  output logic [31:0]        rdata,
  output logic [LINES-1:0]   pend,
  output logic [LINES-1:0]   en,
  output logic [4*LINES-1:0] modes
);
  localparam int CFG_WORDS = (LINES + 7) / 8;
  localparam logic [OFF_W-1:0] CTL_OFF = OFF_W'(16);
  localparam logic [OFF_W-1:0] STS_OFF = OFF_W'(20);
  localparam logic [OFF_W-1:0] CFG_END = OFF_W'(CFG_WORDS * 4);

  logic [3:0]       mode_q [LINES];
  logic [LINES-1:0] en_q, sts_q, hit, clr;
  logic [OFF_W-3:0] word;
  logic             is_cfg, is_ctl, is_sts;

  assign word   = off[OFF_W-1:2];
  assign is_cfg = sel && (off < CFG_END) && (off[1:0] == 2'b00);
  assign is_ctl = sel && (off == CTL_OFF);
  assign is_sts = sel && (off == STS_OFF);

  // Per-line event detection, gated by the line's enable
  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign hit[n] = en_q[n] & trig_hit(mode_q[n], cur[n], prv[n]);
    assign modes[4*n +: 4] = mode_q[n];

    always_ff @(posedge clk) begin
      if (rst)
        mode_q[n] <= '0;
      else if (wr && is_cfg && (int'(word) == n / 8))
        mode_q[n] <= wdata[4*(n%8) +: 4];
    end
  end

  assign clr = (wr && is_sts) ? wdata[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr && is_ctl)
        en_q <= wdata[LINES-1:0];
      // a fresh event outranks a same-cycle clear
      sts_q <= hit | (sts_q & ~clr);
    end
  end

  always_comb begin
    rdata = '0;
    if (is_cfg) begin
      for (int n = 0; n < LINES; n++)
        if (n / 8 == int'(word))
          rdata[4*(n%8) +: 4] = mode_q[n];
    end else if (is_ctl) begin
      rdata = 32'(en_q);
    end else if (is_sts) begin
      rdata = 32'(sts_q);
    end
  end

  assign pend = sts_q;
  assign en   = en_q;
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_BANKS*LINES-1:0] pads,
  output logic                       irq_out
);
  localparam int OFF_W  = 5;
  localparam int STRIDE = 1 << OFF_W;
  localparam int TOTAL  = NUM_BANKS * LINES;
  localparam int BIDX_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic [TOTAL-1:0]  cur, prv, pend_all, en_all;
  logic [4*TOTAL-1:0] mode_all;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [31:0]       rd_mux;
  logic              irq_q;
  logic [31:0]       rdata_q;

  assign rel    = bus_addr - ADDR_W'(BASE_ADDR);
  assign in_win = (bus_addr >= ADDR_W'(BASE_ADDR)) &&
                  (rel < ADDR_W'(NUM_BANKS * STRIDE));

  eint_sync #(.WIDTH(TOTAL)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw (pads),
    .cur (cur),
    .prv (prv)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bsel;
    assign bsel = in_win && (rel[ADDR_W-1:OFF_W] == BIDX_W'(b));

    eint_bank #(.LINES(LINES), .OFF_W(OFF_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .sel   (bsel),
      .wr    (bus_wr),
      .off   (rel[OFF_W-1:0]),
      .wdata (bus_wdata),
      .cur   (cur[b*LINES +: LINES]),
      .prv   (prv[b*LINES +: LINES]),
      .rdata (bank_rd[b]),
      .pend  (pend_all[b*LINES +: LINES]),
      .en    (en_all[b*LINES +: LINES]),
      .modes (mode_all[4*b*LINES +: 4*LINES])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd ? rd_mux : '0;
      irq_q   <= |(pend_all & en_all);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         irq_out,
  input logic [NUM_BANKS*LINES-1:0]   pend_all,
  input logic [NUM_BANKS*LINES-1:0]   en_all,
  input logic [4*NUM_BANKS*LINES-1:0] mode_all
);
  localparam int TOTAL = NUM_BANKS * LINES;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) && !rst |-> (pend_all == '0 && en_all == '0 && mode_all == '0)); // R8

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed)
    irq_out == $past(|(pend_all & en_all))); // R10

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst || !armed)
    (pend_all & ~$past(pend_all) & ~$past(en_all)) == '0); // R5

  for (genvar i = 0; i < TOTAL; i++) begin : g_rsv
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
      $rose(pend_all[i]) |-> ($past(mode_all[4*i +: 4]) <= 4'd4)); // R4
  end
endmodule

bind eint_ctrl eint_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .LINES(LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_out  (irq_out),
  .pend_all (pend_all),
  .en_all   (en_all),
  .mode_all (mode_all)
);

// File: tb/sim_eint_ctrl.sv
`timescale 1ns/1ps
module sim_eint_ctrl;
  localparam int NB = 5;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NB*NL-1:0] pads = '0;
  logic          irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eint_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pads(pads), .irq_out(irq_out)
  );

  function automatic logic [11:0] a_cfg(int b, int n); return 12'(32'h200 + 32*b + 4*(n/8)); endfunction
  function automatic logic [11:0] a_ctl(int b); return 12'(32'h200 + 32*b + 16); endfunction
  function automatic logic [11:0] a_sts(int b); return 12'(32'h200 + 32*b + 20); endfunction

  function automatic bit model_hit(int m, bit v0, bit v1);
    case (m)
      0: return !v0 && v1;
      1: return v0 && !v1;
      2: return v0 || v1;
      3: return !v0 || !v1;
      4: return v0 != v1;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mode(int b, int n, int m);
    logic [31:0] w;
    bus_read(a_cfg(b, n), w);
    w[4*(n%8) +: 4] = 4'(m);
    bus_write(a_cfg(b, n), w);
  endtask

  initial begin
    logic [31:0] r;
    process::self().srandom(32'd1234);
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);

    // R8: reset state
    bus_read(a_cfg(0, 0), r);  check("R8 cfg after reset", r, 0);
    bus_read(a_ctl(4), r);     check("R8 ctl after reset", r, 0);
    bus_read(a_sts(2), r);     check("R8 sts after reset", r, 0);
    check("R8 irq after reset", 32'(irq_out), 0);

    // R1: mode field placement and readback
    bus_write(a_cfg(1, 8), 32'h4321_0432);
    bus_read(a_cfg(1, 8), r);  check("R1 cfg word1 readback", r, 32'h4321_0432);
    bus_write(a_cfg(3, 31), 32'h9000_0000);
    bus_read(a_cfg(3, 31), r); check("R1 cfg line31 field", r, 32'h9000_0000);
    // R3: enable readback
    bus_write(a_ctl(1), 32'h0000_0000);
    bus_write(a_ctl(2), 32'h8000_0001);
    bus_read(a_ctl(2), r);     check("R3 ctl readback", r, 32'h8000_0001);

    // R9: unimplemented offsets while state is non-zero
    bus_read(12'h218 + 12'h020, r); check("R9 offset 0x18", r, 0);
    bus_read(12'h23C, r);           check("R9 offset 0x1C", r, 0);
    bus_read(12'h2A0, r);           check("R9 past last bank", r, 0);
    bus_read(12'h100 + 12'h010, r); check("R9 below base", r, 0);

    // clean up directed setup
    bus_write(a_ctl(2), 0);
    bus_write(a_cfg(1, 8), 0);
    bus_write(a_cfg(3, 31), 0);
    for (int b = 0; b < NB; b++) bus_write(a_sts(b), 32'hFFFF_FFFF);

    // R2/R4/R5: random trials
    for (int t = 0; t < 60; t++) begin
      int b, n, m, sel;
      bit v0, v1, e;
      b = $urandom % NB; n = $urandom % NL;
      sel = $urandom % 8;
      m = (sel < 5) ? sel : 5 + ($urandom % 11);
      v0 = 1'($urandom); v1 = 1'($urandom);
      pads[b*NL + n] = v0;
      wait_cyc(6);
      set_mode(b, n, m);
      bus_write(a_ctl(b), 32'(1) << n);
      bus_write(a_sts(b), 32'(1) << n);
      pads[b*NL + n] = v1;
      wait_cyc(6);
      e = model_hit(m, v0, v1);
      bus_read(a_sts(b), r);
      check($sformatf("R2 R4 R5 trial %0d mode %0d v0=%0d v1=%0d", t, m, v0, v1), r, 32'(e) << n);
      check("R10 irq for trial", 32'(irq_out), 32'(e));
      bus_write(a_ctl(b), 0);
      bus_write(a_sts(b), 32'hFFFF_FFFF);
      set_mode(b, n, 0);
    end
    pads = '0;
    wait_cyc(6);
    for (int b = 0; b < NB; b++) bus_write(a_sts(b), 32'hFFFF_FFFF);

    // R5: pending not set when disabled (rising edge, enable 0)
    bus_write(a_cfg(0, 3), 0);
    pads[3] = 1'b1; wait_cyc(6);
    bus_read(a_sts(0), r); check("R5 disabled line stays clear", r, 0);
    pads[3] = 1'b0; wait_cyc(6);

    // R7: edge and clear in the same cycle
    bus_write(a_ctl(0), 32'h0000_0010);
    bus_write(a_sts(0), 32'hFFFF_FFFF);
    @(negedge clk); pads[4] = 1'b1;
    @(negedge clk);
    bus_write(a_sts(0), 32'h0000_0010);
    bus_read(a_sts(0), r); check("R7 set wins over clear", r, 32'h0000_0010);

    // R10: irq drops one cycle after the clear
    check("R10 irq high before clear", 32'(irq_out), 1);
    bus_write(a_sts(0), 32'h0000_0010);
    check("R10 irq still high right after clear", 32'(irq_out), 1);
    @(negedge clk);
    check("R10 irq low next cycle", 32'(irq_out), 0);

    // R6: write-back clears exactly observed bits; zero bits ignored
    bus_write(a_cfg(2, 0), 32'h0000_0404);   // lines 0,2 both edges
    bus_write(a_cfg(2, 9), 32'h0000_0040);   // line 9 both edges
    bus_write(a_ctl(2), 32'h0000_0205);
    pads[2*NL + 0] = 1'b1; pads[2*NL + 2] = 1'b1;
    wait_cyc(6);
    bus_read(a_sts(2), r); check("R6 two lines pending", r, 32'h0000_0005);
    pads[2*NL + 9] = 1'b1; wait_cyc(6);
    bus_write(a_sts(2), 32'h0000_0005);
    bus_read(a_sts(2), r); check("R6 write-back leaves unseen line", r, 32'h0000_0200);
    bus_write(a_sts(2), 32'h0000_0000);
    bus_read(a_sts(2), r); check("R6 zero write no effect", r, 32'h0000_0200);

    // R10: disable then clear leaves nothing (line 9 switched to high level)
    bus_write(a_cfg(2, 9), 32'h0000_0020);
    wait_cyc(2);
    bus_write(a_ctl(2), 32'h0000_0005);
    bus_write(a_sts(2), 32'h0000_0200);
    wait_cyc(3);
    bus_read(a_sts(2), r); check("R10 disabled level line stays clear", r, 0);
    check("R10 irq low after disable+clear", 32'(irq_out), 0);

    // R5: level mode re-sets immediately after a clear
    bus_write(a_ctl(2), 32'h0000_0200);
    bus_write(a_sts(2), 32'h0000_0200);
    bus_read(a_sts(2), r); check("R5 active level re-sets", r, 32'h0000_0200);

    done = 1;
  end

  initial begin
    fork
      wait (done == 1);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule